// File: doc/BRIEF.md
# Fractional Clock Divider with Triggered Commit

This block turns one of several parent clock-enable streams into a divided clock-enable stream. The division ratio is an unsigned fixed-point number with a configurable count of fraction bits. Software writes a control word through a masked write port. The written fields only go into a staging copy. They reach the running divider when software sets a commit bit. That bit stays set until the change has been applied, and it drops on its own.

The divider field stores the divisor minus one whole unit, so an all-zero field divides by exactly 1.0. An optional pre-divider (integer only) and a parent selector sit in front of the fractional stage. When the second commit bit is built in, that bit is the one that applies them. Each commit waits for the running output period to finish before it takes effect, so a reconfiguration never shortens a pulse interval. One build variant uses a fixed divisor and ignores anything written to the divider field.

Top module: `fdiv_ctrl`

## Requirements
- R1: After reset every staged field and both commit bits read 0, and clk_en pulses on every cycle in which parent 0 ticks. This is divisor 1.0, because the field value 0 stands for a divisor of exactly one.
- R2: The divider field sits at bits [9:4] of the control word. The scaled divisor is the field value plus 2^FRAC_W, with FRAC_W = 2. The divisor is that scaled value divided by four, so field 12 gives one pulse every 4 source ticks.
- R3: A fractional divisor S/4 places pulse k (counted from a commit) on source tick ceil(k*S/4). A pulse is only ever produced on a cycle that follows a source tick.
- R4: The all-ones divider field (63) gives the largest divisor, (2^6 - 1) + 4 = 67 quarters, which is 16.75 ticks.
- R5: A write changes only the control-word bits whose mask bit is 1. No other bit changes, and staged fields hold their value while no write takes place.
- R6: Staged fields have no effect on clk_en until a commit bit is written with 1. The main commit bit is bit 0. It reads 1 from the cycle after that write until the update has been applied, then reads 0. Writing 0 to it has no effect.
- R7: A commit is applied at the end of the output period that is running when it was requested. The interval that ends on the commit pulse equals the old period, and the new period starts right after it.
- R8: The parent selector sits at bits [17:16]. Value n picks parent input n, and the output rate follows that parent's tick rate.
- R9: A selector value with no matching parent (3 or more when there are 3 parents) raises sel_invalid while it is staged. A commit of such a value leaves the running parent unchanged.
- R10: The pre-divider field sits at bits [14:12] and divides the source by field+1. The second commit bit, bit 1, applies the pre-divider and the selector. Bit 0 applies only the divider field.
- R11: In the fixed-divisor variant, writes to the divider field are ignored: the field reads 0, and the period stays at the built-in divisor (3.0 in the second test instance).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data |
| wr_mask | input | 32 | Per-bit write mask; 1 means the bit is written |
| parent_tick | input | NUM_PARENTS | Tick (clock-enable) stream of each parent clock |
| rd_data | output | 32 | Staged control word with pending commit bits |
| sel_invalid | output | 1 | Staged selector names no existing parent |
| clk_en | output | 1 | Divided clock-enable pulse stream |

## Verification
The divider is tried with integer ratios (1, 2, 4), with fractional ratios of 1.5 and 2.25, and with the largest field value. The exact gap sequence separates a correct ceiling pattern from accumulators that are off by one step or that round down. Commits are issued in the middle of a running period, which shows whether the change waits for the period boundary or cuts a runt interval. Parent ticks at rates of one in two and one in three, combined with a pre-divider, show which commit bit applies which field, and show that an invalid selector is held off. A second, fixed-divisor instance on the same write bus shows that divider-field writes are ignored there.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

  // Scaled divisor represented by a stored divider field.
  function automatic int unsigned div_scaled(input int unsigned field,
                                             input int unsigned frac_w);
    return field + (32'd1 << frac_w);
  endfunction

  // Bitwise merge of new data into an old word under a mask.
  function automatic logic [31:0] merge_masked(input logic [31:0] old_word,
                                               input logic [31:0] new_word,
                                               input logic [31:0] mask);
    return (old_word & ~mask) | (new_word & mask);
  endfunction

  // Mask covering a field of a given width at a given shift.
  function automatic logic [31:0] field_mask(input int unsigned shift,
                                             input int unsigned width);
    return ((32'd1 << width) - 32'd1) << shift;
  endfunction

endpackage

// File: rtl/fdiv_regs.sv
module fdiv_regs #(
  parameter int DIV_W        = 6,
  parameter int DIV_SHIFT    = 4,
  parameter int PRE_W        = 3,
  parameter int PRE_SHIFT    = 12,
  parameter int SEL_W        = 2,
  parameter int SEL_SHIFT    = 16,
  parameter int TRIG_BIT     = 0,
  parameter int PRETRIG_BIT  = 1,
  parameter bit HAS_PRETRIG  = 1'b1,
  parameter int FIXED_SCALED = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  input  logic [31:0]      wr_mask,
  input  logic             commit_main,
  input  logic             commit_pre,
  output logic [DIV_W-1:0] st_div,
  output logic [PRE_W-1:0] st_pre,
  output logic [SEL_W-1:0] st_sel,
  output logic             trig_main,
  output logic             trig_pre,
  output logic [31:0]      rd_data
);
  import fdiv_pkg::*;

  logic [31:0] merged;
  logic        set_main;
  logic        set_pre;

  always_comb begin
    rd_data = '0;
    rd_data[DIV_SHIFT +: DIV_W] = st_div;
    rd_data[PRE_SHIFT +: PRE_W] = st_pre;
    rd_data[SEL_SHIFT +: SEL_W] = st_sel;
    rd_data[TRIG_BIT]           = trig_main;
    rd_data[PRETRIG_BIT]        = HAS_PRETRIG ? trig_pre : 1'b0;
  end

  assign merged   = merge_masked(rd_data, wr_data, wr_mask);
  assign set_main = wr_en & wr_mask[TRIG_BIT] & wr_data[TRIG_BIT];
  assign set_pre  = HAS_PRETRIG & wr_en & wr_mask[PRETRIG_BIT] & wr_data[PRETRIG_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_pre    <= '0;
      st_sel    <= '0;
      trig_main <= 1'b0;
      trig_pre  <= 1'b0;
    end else begin
      if (wr_en) begin
        st_pre <= merged[PRE_SHIFT +: PRE_W];
        st_sel <= merged[SEL_SHIFT +: SEL_W];
      end
      // a fresh request wins over a completion in the same cycle
      trig_main <= set_main | (trig_main & ~commit_main);
      trig_pre  <= set_pre  | (trig_pre  & ~commit_pre);
    end
  end

  generate
    if (FIXED_SCALED == 0) begin : g_prog_div
      always_ff @(posedge clk) begin
        if (!rst_n)     st_div <= '0;
        else if (wr_en) st_div <= merged[DIV_SHIFT +: DIV_W];
      end
    end else begin : g_fixed_div
      assign st_div = '0;
    end
  endgenerate

endmodule

// File: rtl/fdiv_src.sv
module fdiv_src #(
  parameter int NUM_PARENTS = 3,
  parameter int SEL_W       = 2,
  parameter int PRE_W       = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_PARENTS-1:0] parent_tick,
  input  logic [SEL_W-1:0]       act_sel,
  input  logic [PRE_W-1:0]       act_pre,
  input  logic                   restart,
  output logic                   src_tick,
  output logic                   pre_tick
);
  logic [PRE_W-1:0] pre_cnt;

  always_comb begin
    src_tick = 1'b0;
    for (int i = 0; i < NUM_PARENTS; i++) begin
      if (act_sel == SEL_W'(i)) src_tick = parent_tick[i];
    end
  end

  assign pre_tick = src_tick && (pre_cnt == act_pre);

  always_ff @(posedge clk) begin
    if (!rst_n)        pre_cnt <= '0;
    else if (restart)  pre_cnt <= '0;
    else if (src_tick) pre_cnt <= pre_tick ? '0 : pre_cnt + 1'b1;
  end

endmodule

// File: rtl/fdiv_accum.sv
module fdiv_accum #(
  parameter int FRAC_W = 2,
  parameter int SC_W   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            restart,
  input  logic [SC_W-1:0] scaled,
  output logic            fire
);
  localparam logic [SC_W-1:0] STEP = SC_W'(1) << FRAC_W;

  logic [SC_W-1:0] acc;
  logic [SC_W-1:0] sum;

  assign sum  = acc + STEP;
  assign fire = tick && (sum >= scaled);

  always_ff @(posedge clk) begin
    if (!rst_n)       acc <= '0;
    else if (restart) acc <= '0;
    else if (tick)    acc <= fire ? sum - scaled : sum;
  end

endmodule

// File: rtl/fdiv_ctrl.sv
module fdiv_ctrl #(
  parameter int FRAC_W       = 2,
  parameter int DIV_W        = 6,
  parameter int DIV_SHIFT    = 4,
  parameter int PRE_W        = 3,
  parameter int PRE_SHIFT    = 12,
  parameter int SEL_W        = 2,
  parameter int SEL_SHIFT    = 16,
  parameter int NUM_PARENTS  = 3,
  parameter int TRIG_BIT     = 0,
  parameter int PRETRIG_BIT  = 1,
  parameter bit HAS_PRETRIG  = 1'b1,
  parameter int FIXED_SCALED = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [31:0]            wr_data,
  input  logic [31:0]            wr_mask,
  input  logic [NUM_PARENTS-1:0] parent_tick,
  output logic [31:0]            rd_data,
  output logic                   sel_invalid,
  output logic                   clk_en
);
  import fdiv_pkg::*;

  localparam int SC_W = DIV_W + 2;

  logic [DIV_W-1:0] st_div, act_div;
  logic [PRE_W-1:0] st_pre, act_pre;
  logic [SEL_W-1:0] st_sel, act_sel;
  logic             trig_main, trig_pre;
  logic             commit_main, commit_pre, restart;
  logic             src_tick, pre_tick, fire;
  logic [SC_W-1:0]  act_scaled;

  fdiv_regs #(
    .DIV_W(DIV_W), .DIV_SHIFT(DIV_SHIFT), .PRE_W(PRE_W), .PRE_SHIFT(PRE_SHIFT),
    .SEL_W(SEL_W), .SEL_SHIFT(SEL_SHIFT), .TRIG_BIT(TRIG_BIT),
    .PRETRIG_BIT(PRETRIG_BIT), .HAS_PRETRIG(HAS_PRETRIG),
    .FIXED_SCALED(FIXED_SCALED)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_mask(wr_mask), .commit_main(commit_main), .commit_pre(commit_pre),
    .st_div(st_div), .st_pre(st_pre), .st_sel(st_sel),
    .trig_main(trig_main), .trig_pre(trig_pre), .rd_data(rd_data)
  );

  fdiv_src #(
    .NUM_PARENTS(NUM_PARENTS), .SEL_W(SEL_W), .PRE_W(PRE_W)
  ) u_src (
    .clk(clk), .rst_n(rst_n), .parent_tick(parent_tick), .act_sel(act_sel),
    .act_pre(act_pre), .restart(restart), .src_tick(src_tick),
    .pre_tick(pre_tick)
  );

  fdiv_accum #(
    .FRAC_W(FRAC_W), .SC_W(SC_W)
  ) u_accum (
    .clk(clk), .rst_n(rst_n), .tick(pre_tick), .restart(restart),
    .scaled(act_scaled), .fire(fire)
  );

  // Commits land only on a pulse, i.e. at an output period boundary.
  assign commit_main = fire & trig_main;
  assign commit_pre  = fire & (HAS_PRETRIG ? trig_pre : trig_main);
  assign restart     = commit_main | commit_pre;
  assign sel_invalid = int'(st_sel) >= NUM_PARENTS;

  generate
    if (FIXED_SCALED == 0) begin : g_prog_scale
      assign act_scaled = SC_W'(div_scaled(32'(act_div), FRAC_W));
    end else begin : g_fixed_scale
      assign act_scaled = SC_W'(FIXED_SCALED);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_div <= '0;
      act_pre <= '0;
      act_sel <= '0;
      clk_en  <= 1'b0;
    end else begin
      clk_en <= fire;
      if (commit_main) act_div <= st_div;
      if (commit_pre) begin
        act_pre <= st_pre;
        if (!sel_invalid) act_sel <= st_sel;
      end
    end
  end

endmodule

// File: rtl/fdiv_ctrl_chk.sv
module fdiv_ctrl_chk #(
  parameter int FRAC_W      = 2,
  parameter int DIV_W       = 6,
  parameter int SEL_W       = 2,
  parameter int SC_W        = 8,
  parameter int NUM_PARENTS = 3,
  parameter int TRIG_BIT    = 0,
  parameter int PRETRIG_BIT = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [31:0]     rd_data,
  input logic            clk_en,
  input logic            src_tick,
  input logic [SEL_W-1:0] act_sel,
  input logic [SC_W-1:0] act_scaled
);
  localparam logic [31:0] FIELD_BITS =
    ~((32'd1 << TRIG_BIT) | (32'd1 << PRETRIG_BIT));
  localparam int MIN_SC = 2 ** FRAC_W;
  localparam int MAX_SC = (2 ** DIV_W - 1) + 2 ** FRAC_W;

  assert_commit_on_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[TRIG_BIT]) |-> clk_en);

  assert_trig_from_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[TRIG_BIT]) |-> $past(wr_en));

  assert_pulse_after_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> $past(src_tick));

  assert_fields_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data & FIELD_BITS));

  assert_active_sel_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(act_sel) < NUM_PARENTS);

  assert_scaled_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(act_scaled) >= MIN_SC && int'(act_scaled) <= MAX_SC);

endmodule

bind fdiv_ctrl fdiv_ctrl_chk #(
  .FRAC_W(FRAC_W), .DIV_W(DIV_W), .SEL_W(SEL_W), .SC_W(SC_W),
  .NUM_PARENTS(NUM_PARENTS), .TRIG_BIT(TRIG_BIT), .PRETRIG_BIT(PRETRIG_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_data(rd_data),
  .clk_en(clk_en), .src_tick(src_tick), .act_sel(act_sel),
  .act_scaled(act_scaled)
);

// File: tb/fdiv_ctrl_test.sv
`timescale 1ns/1ps
module fdiv_ctrl_test;

  localparam logic [31:0] M_TRIG = 32'h0000_0001;
  localparam logic [31:0] M_PRET = 32'h0000_0002;
  localparam logic [31:0] M_DIV  = 32'h0000_03F0;
  localparam logic [31:0] M_PRE  = 32'h0000_7000;
  localparam logic [31:0] M_SEL  = 32'h0003_0000;

  typedef struct { int gap; string tag; } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] wr_mask = '0;
  logic [2:0]  parent_tick;
  logic [31:0] rd_data, rd_fix;
  logic        sel_invalid, sel_inv_fix;
  logic        clk_en, clk_en_fix;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int pcnt = 0;
  int last_pulse = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;

  assign parent_tick = {(pcnt % 3) == 0, (pcnt % 2) == 0, 1'b1};

  fdiv_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_mask(wr_mask), .parent_tick(parent_tick), .rd_data(rd_data),
    .sel_invalid(sel_invalid), .clk_en(clk_en)
  );

  fdiv_ctrl #(.FIXED_SCALED(12)) uut_fixed (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_mask(wr_mask), .parent_tick(parent_tick), .rd_data(rd_fix),
    .sel_invalid(sel_inv_fix), .clk_en(clk_en_fix)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected gap per output pulse.
  always @(negedge clk) begin
    pcnt <= pcnt + 1;
    if (rst_n && clk_en) begin
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        if (e.gap >= 0) check((cyc - last_pulse) == e.gap, e.tag, cyc - last_pulse, e.gap);
      end
      last_pulse <= cyc;
    end
  end

  // Reference: ticks from a commit to pulse k is ceil(k*S/4).
  function automatic int ref_gap(input int s, input int k);
    return ((k * s + 3) / 4) - (((k - 1) * s + 3) / 4);
  endfunction

  task automatic push(input int gap, input string tag);
    exp_t e;
    e.gap = gap;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic reg_write(input logic [31:0] d, input logic [31:0] m);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_mask = m;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; wr_mask = '0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (rd_data[1:0] != 2'b00);
    @(posedge clk); #1;
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic frac_run(input int field, input int n, input string tag);
    reg_write((field << 4) | 1, M_DIV | M_TRIG);
    wait_idle();
    for (int k = 1; k <= n; k++) push(ref_gap(field + 4, k), tag);
    drain();
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int t0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state and divide-by-one
    check(rd_data == 32'd0, "R1 rd_data", rd_data, 0);
    check(sel_invalid == 1'b0, "R1 sel_invalid", sel_invalid, 0);
    @(posedge clk); #1;
    push(-1, "R1"); push(1, "R1 gap"); push(1, "R1 gap"); push(1, "R1 gap");
    drain();

    // R5 masked writes touch only masked bits
    reg_write(32'hFFFF_FC0F | (12 << 4), M_DIV);
    check(rd_data == (12 << 4), "R5 div only", rd_data, 12 << 4);
    reg_write(32'hFFFF_FFFF, M_PRE);
    check(rd_data == ((12 << 4) | (7 << 12)), "R5 pre only", rd_data, (12 << 4) | (7 << 12));
    reg_write(32'h0, M_PRE);
    check(rd_data == (12 << 4), "R5 pre cleared", rd_data, 12 << 4);
    // R11 fixed variant ignores divider writes
    check(rd_fix[9:4] == 6'd0, "R11 field reads 0", rd_fix[9:4], 0);

    // R6 staged value not yet active; writing 0 to trigger does nothing
    reg_write(32'h0, M_TRIG);
    check(rd_data[0] == 1'b0, "R6 zero write", rd_data[0], 0);
    @(posedge clk); #1;
    push(-1, "R6"); push(1, "R6 staged inert"); push(1, "R6 staged inert");
    drain();

    // R2/R6 trigger applies divide-by-4
    reg_write(32'h1, M_TRIG);
    check(rd_data[0] == 1'b1, "R6 pending", rd_data[0], 1);
    wait_idle();
    check(rd_data[0] == 1'b0, "R6 cleared", rd_data[0], 0);
    push(4, "R2 gap"); push(4, "R2 gap"); push(4, "R2 gap");
    drain();

    // R11 fixed instance runs at 3.0
    do @(negedge clk); while (!clk_en_fix);
    t0 = cyc;
    do @(negedge clk); while (!clk_en_fix);
    check((cyc - t0) == 3, "R11 fixed period", cyc - t0, 3);

    // R7 mid-period commit: old period completes, then new one
    do @(negedge clk); while (!clk_en);
    wr_en = 1'b1; wr_data = (4 << 4) | 1; wr_mask = M_DIV | M_TRIG;
    @(posedge clk); #1;
    push(4, "R7 last old period"); push(2, "R7 new"); push(2, "R7 new"); push(2, "R7 new");
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; wr_mask = '0;
    drain();

    // R4 largest divisor, R3 fractional patterns
    frac_run(63, 5, "R4 max gap");
    frac_run(2, 6, "R3 gap 1.5");
    frac_run(5, 6, "R3 gap 2.25");
    frac_run(0, 3, "R2 gap 1.0");

    // R8 parent select through the pre commit
    reg_write(32'h0001_0002, M_SEL | M_PRET);
    wait_idle();
    push(-1, "R8"); push(2, "R8 parent1"); push(2, "R8 parent1"); push(2, "R8 parent1");
    drain();

    // R9 invalid selector is flagged and not applied
    reg_write(32'h0003_0000, M_SEL);
    check(sel_invalid == 1'b1, "R9 flag", sel_invalid, 1);
    reg_write(32'h2, M_PRET);
    wait_idle();
    check(sel_invalid == 1'b1, "R9 flag held", sel_invalid, 1);
    push(-1, "R9"); push(2, "R9 parent kept"); push(2, "R9 parent kept"); push(2, "R9 parent kept");
    drain();

    // R10 main commit leaves pre/select alone, pre commit applies them
    reg_write(32'h0002_2001, M_SEL | M_PRE | M_TRIG);
    wait_idle();
    check(sel_invalid == 1'b0, "R10 valid sel", sel_invalid, 0);
    push(-1, "R10"); push(2, "R10 main only"); push(2, "R10 main only");
    drain();
    reg_write(32'h2, M_PRET);
    wait_idle();
    check(rd_data == 32'h0002_2000, "R10 readback", rd_data, 32'h0002_2000);
    push(-1, "R10"); push(9, "R10 pre+sel"); push(9, "R10 pre+sel"); push(9, "R10 pre+sel");
    drain();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule